// File: doc/BRIEF.md
# Serial Control Register Port

This block is a slave serial port that gives a host controller read and write access to a 32-entry file of 8-bit control registers. The host selects the port with an active-low select line and clocks bits on a serial clock. Every transfer starts with an 8-bit command. The command gives the direction, a burst length of one to four bytes and a start address. Data bytes follow, and the port moves through the addresses by itself. The port runs in the system clock domain. It brings the serial select, clock and data in through synchronizer stages and acts on the detected serial-clock edges.

Register 00h configures the port itself. One bit switches the bit order of every frame to LSB first, which also reverses the direction of address stepping. One bit turns the input data line into a shared read/write line (3-wire) in place of the separate output line (4-wire). One bit clears the rest of the register file. These bits take effect as soon as the byte that holds them is complete, including in the middle of a burst. Each line's tri-state is given as a separate output-enable pin.

A controller finite-state machine steps through its states. Idle means the port is deselected. Command shifts in the 8 command bits. Write-data and read-data carry the burst bytes. Done ignores surplus clocks. The transitions are: select (Idle→Command), command-read (Command→Read-data), command-write (Command→Write-data), last-byte (Read-data or Write-data→Done), and deselect (any state→Idle).

Top module: `spirp_top`

## Requirements
- R1: The 8 serial-clock rising edges after select form the command byte. Bit 7 = 1 means read and 0 means write. Bits 6:5 give the burst length (00→1, 01→2, 10→3, 11→4 bytes). Bits 4:0 give the start address.
- R2: During a write burst, each data byte is stored in the current register as soon as its eighth bit is sampled.
- R3: After each data byte the address steps. In MSB-first order it decrements, so 00h is followed by 1Fh. In LSB-first order it increments, so 1Fh is followed by 00h.
- R4: Deselecting the port returns it to the start of a command, whatever its state. A command or data byte that is only partly shifted writes nothing.
- R5: Writing a 1 to bit 5 of register 00h sets every other register to its default value. Register 00h takes the other bits of the written byte, and bit 5 always reads back 0.
- R6: The hardware reset input sets every register to its default, including 00h. Register 01h defaults to 04h and all other registers default to 00h.
- R7: Bit 6 of register 00h set to 1 selects LSB-first order for command and data bytes. A new value takes effect on the next byte of the same burst, and the address step after that byte already uses it.
- R8: Both output enables are low while the port is deselected. The separate data output is enabled while the port is selected in 4-wire mode (bit 7 of 00h = 0). In 3-wire mode (bit 7 = 1) the shared line is enabled only after a read command, and only until deselect.
- R9: Read data is changed on serial-clock falling edges, in the selected bit order, so that the host can sample it on the following rising edge. The first data bit is driven on the falling edge that follows the last command bit.
- R10: Registers at or above the implemented count (0Dh to 1Fh by default) read 00h and ignore writes.
- R11: Once the burst length is reached, further serial clocks are ignored until the next deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cs_n | input | 1 | Active-low port select |
| sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Serial data input (receive side of the shared line) |
| sdio_out | output | 1 | Read data for the shared line |
| sdio_oe | output | 1 | Drive enable for the shared line |
| sdo_out | output | 1 | Read data for the separate output line |
| sdo_oe | output | 1 | Drive enable for the separate output line |

## Verification
The bench builds the port with 13 implemented registers and two synchronizer stages. Both the implemented region and the inert 0Dh–1Fh region can therefore be reached in one 32-address space. Each wrap (00h↔1Fh) borders a real register on one side and an inert one on the other, so a burst across it shows both the stepping direction and the filtering of writes to unimplemented addresses. Every burst length is swept against every start address in 01h–0Ch that keeps the burst clear of register 00h. Further runs cover both bit orders, both wire modes, a switch of bit order in the middle of a burst, a soft reset, a hardware reset and aborted frames.

// File: rtl/spirp_pkg.sv
package spirp_pkg;
    localparam int ADDR_W = 5;
    localparam int NREG   = 1 << ADDR_W;
    localparam int DATA_W = 8;

    localparam int CFG_BIDIR = 7;
    localparam int CFG_LSB   = 6;
    localparam int CFG_SRST  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INSTR,
        ST_WRITE,
        ST_READ,
        ST_DONE
    } state_t;

    function automatic logic [DATA_W-1:0] reg_default(input logic [ADDR_W-1:0] a);
        return (a == ADDR_W'(1)) ? 8'h04 : 8'h00;
    endfunction
endpackage

// File: rtl/spirp_sync.sv
module spirp_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic cs_act,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sdi_q
);
    logic [SYNC_STAGES-1:0] cs_sh;
    logic [SYNC_STAGES-1:0] ck_sh;
    logic [SYNC_STAGES-1:0] di_sh;
    logic                   ck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_sh <= '1;
            ck_sh <= '0;
            di_sh <= '0;
            ck_d  <= 1'b0;
        end else begin
            cs_sh <= {cs_sh[SYNC_STAGES-2:0], cs_n};
            ck_sh <= {ck_sh[SYNC_STAGES-2:0], sclk};
            di_sh <= {di_sh[SYNC_STAGES-2:0], sdi};
            ck_d  <= ck_sh[SYNC_STAGES-1];
        end
    end

    assign cs_act    = ~cs_sh[SYNC_STAGES-1];
    assign sclk_rise =  ck_sh[SYNC_STAGES-1] & ~ck_d;
    assign sclk_fall = ~ck_sh[SYNC_STAGES-1] &  ck_d;
    assign sdi_q     =  di_sh[SYNC_STAGES-1];
endmodule

// File: rtl/spirp_regfile.sv
module spirp_regfile
    import spirp_pkg::*;
#(
    parameter int IMPL_COUNT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              cfg_bidir,
    output logic              cfg_lsb
);
    logic [DATA_W-1:0] regs [NREG];
    logic              srst;

    assign srst = wr_en && (wr_addr == '0) && wr_data[CFG_SRST];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i >= IMPL_COUNT) begin : g_none
            assign regs[i] = '0;
        end else if (i == 0) begin : g_cfg
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= reg_default('0);
                else if (wr_en && (wr_addr == '0))
                    q <= wr_data & ~(DATA_W'(1) << CFG_SRST);
            end
            assign regs[i] = q;
        end else begin : g_rw
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= reg_default(ADDR_W'(i));
                else if (srst)
                    q <= reg_default(ADDR_W'(i));
                else if (wr_en && (wr_addr == ADDR_W'(i)))
                    q <= wr_data;
            end
            assign regs[i] = q;
        end
    end

    assign rd_data   = regs[rd_addr];
    assign cfg_bidir = regs[0][CFG_BIDIR];
    assign cfg_lsb   = regs[0][CFG_LSB];
endmodule

// File: rtl/spirp_ctrl.sv
module spirp_ctrl
    import spirp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi,
    input  logic              cfg_lsb,
    input  logic [DATA_W-1:0] rd_data,
    output state_t            state,
    output logic              wr_en,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wr_data,
    output logic              out_bit,
    output logic              rd_seen
);
    state_t            nxt;
    logic [2:0]        bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        left;
    logic              out_q;
    logic              seen_q;

    logic [DATA_W-1:0] rx_next;
    logic              shifting;
    logic              byte_done;
    logic              lsb_eff;
    logic [ADDR_W-1:0] addr_step;

    always_comb begin
        rx_next   = cfg_lsb ? {sdi, shreg[DATA_W-1:1]} : {shreg[DATA_W-2:0], sdi};
        shifting  = (state == ST_INSTR) || (state == ST_WRITE) || (state == ST_READ);
        byte_done = shifting && sclk_rise && (bit_cnt == 3'd7);
        // a byte landing in the config register steers the very next step
        lsb_eff   = ((state == ST_WRITE) && (addr == '0)) ? rx_next[CFG_LSB] : cfg_lsb;
        addr_step = lsb_eff ? addr + ADDR_W'(1) : addr - ADDR_W'(1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (!cs_act) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_INSTR;
                ST_INSTR: if (byte_done) nxt = rx_next[7] ? ST_READ : ST_WRITE;
                ST_WRITE: if (byte_done && (left == 2'd0)) nxt = ST_DONE;
                ST_READ:  if (byte_done && (left == 2'd0)) nxt = ST_DONE;
                ST_DONE:  nxt = ST_DONE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            addr    <= '0;
            left    <= '0;
            out_q   <= 1'b0;
            seen_q  <= 1'b0;
        end else if (!cs_act) begin
            bit_cnt <= '0;
            shreg   <= '0;
            out_q   <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            if (shifting && sclk_rise) begin
                bit_cnt <= bit_cnt + 3'd1;
                shreg   <= rx_next;
            end
            if (byte_done) begin
                if (state == ST_INSTR) begin
                    addr   <= rx_next[ADDR_W-1:0];
                    left   <= rx_next[6:5];
                    seen_q <= rx_next[7];
                end else begin
                    addr <= addr_step;
                    left <= left - 2'd1;
                end
            end
            if (sclk_fall && (state == ST_READ))
                out_q <= cfg_lsb ? rd_data[bit_cnt] : rd_data[3'd7 - bit_cnt];
        end
    end

    // outputs
    always_comb begin
        wr_en   = (state == ST_WRITE) && byte_done;
        addr_o  = addr;
        wr_data = rx_next;
        out_bit = out_q;
        rd_seen = seen_q;
    end
endmodule

// File: rtl/spirp_top.sv
module spirp_top
    import spirp_pkg::*;
#(
    parameter int IMPL_COUNT  = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdio_in,
    output logic sdio_out,
    output logic sdio_oe,
    output logic sdo_out,
    output logic sdo_oe
);
    logic              cs_act;
    logic              sclk_rise;
    logic              sclk_fall;
    logic              sdi_q;
    logic              cfg_bidir;
    logic              cfg_lsb;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic              out_bit;
    logic              rd_seen;
    state_t            state;

    spirp_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdio_in),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi_q     (sdi_q)
    );

    spirp_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi       (sdi_q),
        .cfg_lsb   (cfg_lsb),
        .rd_data   (rd_data),
        .state     (state),
        .wr_en     (wr_en),
        .addr_o    (wr_addr),
        .wr_data   (wr_data),
        .out_bit   (out_bit),
        .rd_seen   (rd_seen)
    );

    spirp_regfile #(.IMPL_COUNT(IMPL_COUNT)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (wr_addr),
        .rd_data   (rd_data),
        .cfg_bidir (cfg_bidir),
        .cfg_lsb   (cfg_lsb)
    );

    assign sdio_out = out_bit;
    assign sdo_out  = out_bit;
    assign sdio_oe  = cfg_bidir && rd_seen && ((state == ST_READ) || (state == ST_DONE));
    assign sdo_oe   = cs_act && !cfg_bidir;
endmodule

// File: rtl/spirp_checker.sv
module spirp_checker
    import spirp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              cs_act,
    input logic              sdo_oe,
    input logic              sdio_oe,
    input logic              cfg_bidir,
    input logic              cfg_lsb,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input state_t            state
);
    // R8: the two data lines never drive together
    a_r8_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdo_oe && sdio_oe));

    // R8: a settled deselect leaves both lines released
    a_r8_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> (!sdo_oe && !sdio_oe));

    // R4: deselect forces the controller back to idle
    a_r4_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (state == ST_IDLE));

    // R7: config bits follow a write to register 00h on the next cycle
    a_r7_cfg_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == '0)) |=> ({cfg_bidir, cfg_lsb} == $past(wr_data[7:6])));

    // R2: at most one register write per serial byte
    a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

bind spirp_top spirp_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .cs_act    (cs_act),
    .sdo_oe    (sdo_oe),
    .sdio_oe   (sdio_oe),
    .cfg_bidir (cfg_bidir),
    .cfg_lsb   (cfg_lsb),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .state     (state)
);

// File: tb/spirp_top_tb.sv
module spirp_top_tb_top;
    localparam int IMPL = 13;
    localparam int HALF = 160;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdio_in = 1'b0;
    logic sdio_out, sdio_oe, sdo_out, sdo_oe;

    always #10 clk = ~clk;

    spirp_top #(.IMPL_COUNT(IMPL), .SYNC_STAGES(2)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .sdio_in  (sdio_in),
        .sdio_out (sdio_out),
        .sdio_oe  (sdio_oe),
        .sdo_out  (sdo_out),
        .sdo_oe   (sdo_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] mdl [32];
    bit m_lsb = 1'b0;
    bit m_bidir = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_default(input int a);
        return (a == 1) ? 8'h04 : 8'h00;
    endfunction

    task automatic mdl_reset_all();
        for (int a = 0; a < 32; a++) mdl[a] = (a < IMPL) ? exp_default(a) : 8'h00;
        m_lsb = 1'b0;
        m_bidir = 1'b0;
    endtask

    task automatic mdl_write(input int a, input logic [7:0] d);
        if (a >= IMPL) return;
        if (a == 0) begin
            mdl[0] = d & 8'hDF;
            m_bidir = d[7];
            m_lsb = d[6];
            if (d[5]) for (int i = 1; i < IMPL; i++) mdl[i] = exp_default(i);
        end else begin
            mdl[a] = d;
        end
    endtask

    function automatic logic [4:0] next_addr(input logic [4:0] a);
        return m_lsb ? a + 5'd1 : a - 5'd1;
    endfunction

    task automatic spi_bit(input logic din, output logic dout);
        sdio_in = din;
        #(HALF);
        if (m_bidir) dout = sdio_oe ? sdio_out : 1'bz;
        else         dout = sdo_oe  ? sdo_out  : 1'bz;
        sclk = 1'b1;
        #(HALF);
        sclk = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] tx, input bit lsb, output logic [7:0] rx);
        for (int i = 0; i < 8; i++) begin
            int idx;
            logic b;
            idx = lsb ? i : 7 - i;
            spi_bit(tx[idx], b);
            rx[idx] = b;
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        #(HALF);
    endtask

    task automatic cs_high();
        cs_n = 1'b1;
        #(2 * HALF);
        check("R8 deselected lines released", {30'd0, sdio_oe, sdo_oe}, 32'd0);
    endtask

    task automatic write_burst(input logic [4:0] a, input int len, input logic [31:0] d);
        logic [7:0] rx;
        logic [4:0] cur;
        cs_low();
        spi_byte({1'b0, 2'(len - 1), a}, m_lsb, rx);
        check("R8 no shared-line drive on write", {30'd0, sdio_oe, sdo_oe}, {30'd0, 1'b0, !m_bidir});
        cur = a;
        for (int k = 0; k < len; k++) begin
            spi_byte(d[8*k +: 8], m_lsb, rx);
            mdl_write(int'(cur), d[8*k +: 8]);
            cur = next_addr(cur);
        end
        cs_high();
    endtask

    task automatic read_burst(input logic [4:0] a, input int len, input string req);
        logic [7:0] rx;
        logic [4:0] cur;
        cs_low();
        spi_byte({1'b1, 2'(len - 1), a}, m_lsb, rx);
        cur = a;
        for (int k = 0; k < len; k++) begin
            spi_byte(8'h00, m_lsb, rx);
            check($sformatf("%s R9 addr %h", req, cur), {24'd0, rx}, {24'd0, mdl[cur]});
            if (k == 0)
                check("R8 read drive enables", {30'd0, sdio_oe, sdo_oe}, {30'd0, m_bidir, !m_bidir});
            cur = next_addr(cur);
        end
        cs_high();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rx;
        logic b;
        mdl_reset_all();
        repeat (5) @(posedge clk);
        #5;
        rst_n = 1'b1;
        #(2 * HALF);
        check("R8 reset lines released", {30'd0, sdio_oe, sdo_oe}, 32'd0);

        // R6 R10: every address after reset, single-byte reads
        for (int a = 0; a < 32; a++) read_burst(5'(a), 1, "R6 R10 reset value");

        // R1 R2 R3: every burst length from every start that stays clear of 00h
        for (int len = 1; len <= 4; len++) begin
            for (int s = len; s < IMPL; s++) begin
                logic [31:0] d;
                for (int k = 0; k < 4; k++) d[8*k +: 8] = 8'((s * 16 + len * 4 + k) ^ 8'hA5);
                write_burst(5'(s), len, d);
                read_burst(5'(s), len, "R1 R2 R3 sweep");
            end
        end

        // R3: descending wrap 01h, 00h, 1Fh
        read_burst(5'h01, 3, "R3 wrap down");

        // R10: writes to unimplemented addresses vanish
        write_burst(5'h1F, 2, 32'h0000_C3E7);
        read_burst(5'h1F, 2, "R10 unimplemented");

        // R4: partial data byte dropped
        cs_low();
        spi_byte({3'b000, 5'h05}, m_lsb, rx);
        for (int i = 0; i < 5; i++) spi_bit(~mdl[5][7 - i], b);
        cs_high();
        read_burst(5'h05, 1, "R4 partial byte discarded");

        // R4: partial command then fresh frame
        cs_low();
        for (int i = 0; i < 3; i++) spi_bit(1'b1, b);
        cs_high();
        write_burst(5'h06, 1, 32'h0000_0099);
        read_burst(5'h06, 1, "R4 restart after abort");

        // R11: clocks past the burst end are ignored
        cs_low();
        spi_byte({3'b000, 5'h07}, m_lsb, rx);
        spi_byte(8'h11, m_lsb, rx);
        mdl_write(7, 8'h11);
        spi_byte(8'h22, m_lsb, rx);
        cs_high();
        read_burst(5'h07, 1, "R11 burst end");
        read_burst(5'h06, 1, "R11 neighbour untouched");

        // R7 R3: LSB-first order with ascending wrap
        write_burst(5'h00, 1, 32'h0000_0040);
        write_burst(5'h0A, 3, 32'h00_5C_3B_1D);
        read_burst(5'h0A, 3, "R7 lsb-first burst");
        read_burst(5'h1E, 4, "R3 wrap up");
        write_burst(5'h00, 1, 32'h0000_0000);

        // R7: order switch inside one burst
        write_burst(5'h00, 2, 32'h0000_3140);
        read_burst(5'h01, 1, "R7 mid-burst switch");
        write_burst(5'h00, 1, 32'h0000_0000);

        // R8 R9: 3-wire reads in both orders
        write_burst(5'h00, 1, 32'h0000_0080);
        read_burst(5'h02, 2, "R8 3-wire msb");
        write_burst(5'h00, 1, 32'h0000_00C0);
        read_burst(5'h0B, 2, "R8 3-wire lsb");
        write_burst(5'h00, 1, 32'h0000_0000);

        // R5: soft reset
        write_burst(5'h00, 1, 32'h0000_0023);
        read_burst(5'h00, 1, "R5 config kept, reset bit reads 0");
        read_burst(5'h01, 1, "R5 default restored");
        read_burst(5'h0C, 4, "R5 cleared");

        // R6: hardware reset
        write_burst(5'h03, 1, 32'h0000_0077);
        write_burst(5'h00, 1, 32'h0000_0043);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        rst_n = 1'b1;
        mdl_reset_all();
        #(2 * HALF);
        read_burst(5'h00, 1, "R6 config cleared");
        read_burst(5'h03, 1, "R6 register cleared");
        read_burst(5'h01, 1, "R6 default");

        finish_run();
    end
endmodule